// File: doc/BRIEF.md
# I2C Slave Address Decoder

This block is the address-phase front end of an I2C bus slave. It synchronises the SCL and SDA lines to the system clock, detects START and STOP conditions, and shifts in the first byte that follows each START. The upper seven bits of that byte are compared with the device's own address. That address is formed from two leading ones, four programmable configuration bits and one external strap bit. A chip therefore has 32 possible addresses on one bus.

When the address matches, the block pulls SDA low for the acknowledge slot. It then holds an `addressed` flag and reports the direction bit. The all-zero general-call address is acknowledged by every device. The byte that follows a general call is also acknowledged, and it is presented as a command code with a one-cycle valid strobe. A START that is followed directly by a STOP, with no bits in between, is flagged by a one-cycle illegal-format pulse. A status input that says the strap pin is floating is reported as a registered fault flag.

Traffic that is not addressed to the device is ignored until the next START or STOP. Data transfer after the address phase is left to the logic that surrounds the block.

Top module: `i2c_addr_front`

## Requirements
- R1: The device address, MSB first, is 1, 1, progBits[3], progBits[2], progBits[1], progBits[0], strapBit. When bits 7..1 of the first byte after a START equal it, the block acknowledges and raises `addressed`, which stays high until the next START or STOP.
- R2: Bit 0 of the address byte sets `readMode`: 1 means the master reads and 0 means the master writes. It is valid while `addressed` is high.
- R3: The address 0000000 (general call) is acknowledged for every setting of progBits and strapBit, and it does not raise `addressed`.
- R4: After an acknowledged general call, the next byte (MSB first) is acknowledged and appears on `gcCmd` together with a `gcValid` pulse that lasts exactly one cycle.
- R5: A repeated START at any point restarts the bit count, so the byte that follows is decoded as a new address byte.
- R6: A START followed by a STOP with no SCL rising edge in between raises `illegalPulse` for exactly one cycle and leaves `addressed` low. A STOP after any address bits raises no pulse.
- R7: `strapFault` follows `strapOpen` with one clock of delay.
- R8: `sdaPullLow` goes high only in the acknowledge slot. It is set at the SCL falling edge after the eighth bit of a byte and cleared at the SCL falling edge after the ninth bit. It is never high while one of the eight data bits is on the bus.
- R9: After a non-matching, non-general-call address, SDA stays released, and later bytes are not decoded until the next START or STOP.
- R10: A STOP clears `addressed` and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level (wired bus value) |
| progBits | input | 4 | Programmable address bits |
| strapBit | input | 1 | External strap address bit |
| strapOpen | input | 1 | Strap pin floating status |
| sdaPullLow | output | 1 | 1 pulls SDA low (open-drain enable) |
| addressed | output | 1 | Device selected by its own address |
| readMode | output | 1 | Direction of the current access, 1 = read |
| gcValid | output | 1 | One-cycle strobe, general-call command captured |
| gcCmd | output | 8 | General-call command byte |
| illegalPulse | output | 1 | One-cycle strobe for START directly followed by STOP |
| strapFault | output | 1 | Registered strap-open fault flag |

## Verification
On every cycle, the assertions check the following:
- The strobes last one cycle.
- `sdaPullLow` changes only while the synchronised SCL is low, or at a bus condition.
- `addressed` and the general-call strobe always coincide with an acknowledge being driven.
- A STOP always deselects the device.
- `readMode` is stable while the device is selected.
- The strap fault follows its input.

Only the bench scenarios can show the rest:
- That the address is actually composed correctly across all 32 configurations.
- That non-matching traffic stays ignored.
- That repeated STARTs re-decode the address.
- That general-call command bytes come through intact.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef struct packed {
    logic clearBits;
    logic shiftBit;
    logic latchCmd;
  } ctrl_strobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_CMD,
    ST_CMDACK,
    ST_HOLD,
    ST_SKIP
  } bus_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclRaw,
  input  logic sdaRaw,
  output logic sclLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev, sdaLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclRaw};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaRaw};
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclLvl   = sclPipe[STAGES-1];
  assign sdaLvl   = sdaPipe[STAGES-1];
  assign sclRise  = sclLvl & ~sclPrev;
  assign sclFall  = ~sclLvl & sclPrev;
  assign startDet = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopDet  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;
endmodule

// File: rtl/i2c_addr_dp.sv
module i2c_addr_dp
  import i2c_addr_pkg::*;
#(
  parameter int PROG_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobes_t     strobes,
  input  logic              sdaBit,
  input  logic [PROG_W-1:0] progBits,
  input  logic              strapBit,
  output logic              byteFull,
  output logic              bitsZero,
  output logic              addrEq,
  output logic              gcEq,
  output logic              dirBit,
  output logic [BYTE_W-1:0] cmdOut
);
  localparam int FIXED_W = ADDR_W - PROG_W - 1;

  logic [BYTE_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [ADDR_W-1:0] devAddr;

  assign devAddr = {{FIXED_W{1'b1}}, progBits, strapBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      cmdOut   <= '0;
    end else begin
      if (strobes.clearBits) begin
        bitCnt <= '0;
      end else if (strobes.shiftBit) begin
        shiftReg <= {shiftReg[BYTE_W-2:0], sdaBit};
        bitCnt   <= bitCnt + 1'b1;
      end
      if (strobes.latchCmd) cmdOut <= shiftReg;
    end
  end

  assign byteFull = (bitCnt == CNT_W'(BYTE_W));
  assign bitsZero = (bitCnt == '0);
  assign addrEq   = (shiftReg[BYTE_W-1 -: ADDR_W] == devAddr);
  assign gcEq     = (shiftReg[BYTE_W-1 -: ADDR_W] == '0);
  assign dirBit   = shiftReg[0];
endmodule

// File: rtl/i2c_addr_ctrl.sv
module i2c_addr_ctrl
  import i2c_addr_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclRise,
  input  logic          sclFall,
  input  logic          startDet,
  input  logic          stopDet,
  input  logic          byteFull,
  input  logic          bitsZero,
  input  logic          addrEq,
  input  logic          gcEq,
  input  logic          dirBit,
  input  logic          strapOpen,
  output ctrl_strobes_t strobes,
  output logic          sdaLow,
  output logic          addressed,
  output logic          readMode,
  output logic          gcValid,
  output logic          illegalPulse,
  output logic          strapFault
);
  bus_state_e state;
  logic       gcSeen;

  always_comb begin
    strobes           = '0;
    strobes.clearBits = startDet | (state == ST_ACK && sclFall);
    strobes.shiftBit  = sclRise & ~byteFull & (state == ST_ADDR || state == ST_CMD);
    strobes.latchCmd  = (state == ST_CMD) & sclFall & byteFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      sdaLow       <= 1'b0;
      addressed    <= 1'b0;
      readMode     <= 1'b0;
      gcValid      <= 1'b0;
      illegalPulse <= 1'b0;
      gcSeen       <= 1'b0;
      strapFault   <= 1'b0;
    end else begin
      strapFault   <= strapOpen;
      gcValid      <= 1'b0;
      illegalPulse <= 1'b0;
      if (startDet) begin
        state     <= ST_ADDR;
        sdaLow    <= 1'b0;
        addressed <= 1'b0;
        gcSeen    <= 1'b0;
      end else if (stopDet) begin
        illegalPulse <= (state == ST_ADDR) & bitsZero;
        state        <= ST_IDLE;
        sdaLow       <= 1'b0;
        addressed    <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: if (sclFall && byteFull) begin
            if (addrEq || gcEq) begin
              sdaLow <= 1'b1;
              gcSeen <= gcEq;
              state  <= ST_ACK;
              if (addrEq) begin
                addressed <= 1'b1;
                readMode  <= dirBit;
              end
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_ACK: if (sclFall) begin
            sdaLow <= 1'b0;
            state  <= gcSeen ? ST_CMD : ST_HOLD;
          end
          ST_CMD: if (sclFall && byteFull) begin
            sdaLow  <= 1'b1;
            gcValid <= 1'b1;
            state   <= ST_CMDACK;
          end
          ST_CMDACK: if (sclFall) begin
            sdaLow <= 1'b0;
            state  <= ST_SKIP;
          end
          default: state <= state;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_addr_front.sv
module i2c_addr_front
  import i2c_addr_pkg::*;
#(
  parameter int PROG_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [PROG_W-1:0] progBits,
  input  logic              strapBit,
  input  logic              strapOpen,
  output logic              sdaPullLow,
  output logic              addressed,
  output logic              readMode,
  output logic              gcValid,
  output logic [BYTE_W-1:0] gcCmd,
  output logic              illegalPulse,
  output logic              strapFault
);
  ctrl_strobes_t strobes;
  logic sclLvl, sclRise, sclFall, startDet, stopDet, sdaBit;
  logic byteFull, bitsZero, addrEq, gcEq, dirBit;

  assign sdaBit = sdaIn;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclRaw(sclIn), .sdaRaw(sdaIn),
    .sclLvl(sclLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2c_addr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .byteFull(byteFull),
    .bitsZero(bitsZero), .addrEq(addrEq), .gcEq(gcEq), .dirBit(dirBit),
    .strapOpen(strapOpen), .strobes(strobes), .sdaLow(sdaPullLow),
    .addressed(addressed), .readMode(readMode), .gcValid(gcValid),
    .illegalPulse(illegalPulse), .strapFault(strapFault)
  );

  i2c_addr_dp #(.PROG_W(PROG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sdaBit(sdaBit),
    .progBits(progBits), .strapBit(strapBit), .byteFull(byteFull),
    .bitsZero(bitsZero), .addrEq(addrEq), .gcEq(gcEq), .dirBit(dirBit),
    .cmdOut(gcCmd)
  );
endmodule

// File: rtl/i2c_addr_front_chk.sv
module i2c_addr_front_chk (
  input logic clk,
  input logic rstN,
  input logic sclLvl,
  input logic startDet,
  input logic stopDet,
  input logic sdaPullLow,
  input logic addressed,
  input logic readMode,
  input logic gcValid,
  input logic illegalPulse,
  input logic strapOpen,
  input logic strapFault
);
  // R6
  illegal_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalPulse |=> !illegalPulse);
  // R6
  illegal_not_addressed_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalPulse |-> !addressed);
  // R4
  gc_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    gcValid |=> !gcValid);
  // R4
  gc_with_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    gcValid |-> sdaPullLow);
  // R1
  select_with_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addressed) |-> sdaPullLow);
  // R8
  ack_edge_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> (!sclLvl || $past(startDet || stopDet)));
  // R2
  dir_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addressed && $past(addressed)) |-> $stable(readMode));
  // R10
  stop_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !addressed);
  // R7
  strap_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (strapFault == $past(strapOpen)));
endmodule

bind i2c_addr_front i2c_addr_front_chk u_chk (
  .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .startDet(startDet),
  .stopDet(stopDet), .sdaPullLow(sdaPullLow), .addressed(addressed),
  .readMode(readMode), .gcValid(gcValid), .illegalPulse(illegalPulse),
  .strapOpen(strapOpen), .strapFault(strapFault)
);

// File: tb/i2c_addr_front_tb.sv
module i2c_addr_front_tb;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1, msda = 1'b1;
  logic [3:0] progBits = '0;
  logic strapBit = 1'b0, strapOpen = 1'b0;
  logic sdaPullLow, addressed, readMode, gcValid, illegalPulse, strapFault;
  logic [7:0] gcCmd;
  logic sdaBus;

  int checks = 0, errors = 0;
  int illCnt = 0, gcCnt = 0, earlyCnt = 0, lateCnt = 0;
  logic [7:0] gcCapt = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign sdaBus = msda & ~sdaPullLow;

  i2c_addr_front u_dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus),
    .progBits(progBits), .strapBit(strapBit), .strapOpen(strapOpen),
    .sdaPullLow(sdaPullLow), .addressed(addressed), .readMode(readMode),
    .gcValid(gcValid), .gcCmd(gcCmd), .illegalPulse(illegalPulse),
    .strapFault(strapFault)
  );

  always @(posedge clk) begin
    if (illegalPulse) illCnt++;
    if (gcValid) begin
      gcCnt++;
      gcCapt = gcCmd;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    msda = 1'b1; waitQ(Q);
    scl = 1'b1; waitQ(Q);
    msda = 1'b0; waitQ(Q);
    scl = 1'b0; waitQ(Q);
  endtask

  task automatic busStop();
    msda = 1'b0; waitQ(Q);
    scl = 1'b1; waitQ(Q);
    msda = 1'b1; waitQ(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; waitQ(Q);
      scl = 1'b1; waitQ(Q);
      if (sdaPullLow) earlyCnt++;   // R8: no drive in data slots
      waitQ(Q);
      scl = 1'b0; waitQ(Q);
    end
    msda = 1'b1; waitQ(Q);
    scl = 1'b1; waitQ(Q);
    ack = sdaPullLow;
    waitQ(Q);
    scl = 1'b0; waitQ(Q);
    if (sdaPullLow) lateCnt++;      // R8: released after ninth fall
  endtask

  initial begin
    bit ack;
    logic [6:0] dev, bad;
    int ill0, gc0;
    waitQ(5);
    rstN = 1'b1;
    waitQ(3);
    chk(!sdaPullLow && !addressed && !gcValid && !illegalPulse && !strapFault,
        "reset R1", int'(addressed), 0);

    // R1 R2 R5 R9 R10 sweep over all 32 address configurations
    ill0 = illCnt;
    for (int cfg = 0; cfg < 32; cfg++) begin
      progBits = cfg[4:1];
      strapBit = cfg[0];
      dev = 7'h60 | 7'(cfg);
      bad = dev ^ (7'h1 << (cfg % 5));
      waitQ(2);
      busStart();
      sendByte({dev, 1'b0}, ack);
      chk(ack, "R1 ack own address write", int'(ack), 1);
      chk(addressed && !readMode, "R2 write direction", int'(readMode), 0);
      busStart();
      sendByte({dev, 1'b1}, ack);
      chk(ack && addressed, "R5 repeated start re-decode", int'(ack), 1);
      chk(readMode, "R2 read direction", int'(readMode), 1);
      busStop();
      chk(!addressed, "R10 stop deselects", int'(addressed), 0);
      busStart();
      sendByte({bad, 1'b0}, ack);
      chk(!ack && !addressed, "R9 mismatch no ack", int'(ack), 0);
      sendByte({dev, 1'b0}, ack);
      chk(!ack && !addressed, "R9 ignored until start", int'(ack), 0);
      busStart();
      sendByte({dev, 1'b0}, ack);
      chk(ack && addressed, "R5 start after ignore", int'(ack), 1);
      busStop();
    end
    chk(earlyCnt == 0, "R8 no ack in data slots", earlyCnt, 0);
    chk(lateCnt == 0, "R8 ack released after ninth bit", lateCnt, 0);
    chk(illCnt == ill0, "R6 no pulse on normal stop", illCnt - ill0, 0);

    // R3 R4 general call with several command codes and configurations
    for (int k = 0; k < 6; k++) begin
      logic [7:0] cmd;
      cmd = 8'((k * 8'h5B) ^ 8'hA5);
      progBits = 4'(k * 3);
      strapBit = k[0];
      gc0 = gcCnt;
      busStart();
      sendByte({7'h00, k[1]}, ack);
      chk(ack, "R3 general call ack", int'(ack), 1);
      chk(!addressed, "R3 general call not addressed", int'(addressed), 0);
      sendByte(cmd, ack);
      chk(ack, "R4 command byte ack", int'(ack), 1);
      chk(gcCnt == gc0 + 1, "R4 single valid pulse", gcCnt - gc0, 1);
      chk(gcCapt == cmd, "R4 command value", int'(gcCapt), int'(cmd));
      busStop();
    end

    // R6 START directly followed by STOP
    for (int k = 0; k < 3; k++) begin
      ill0 = illCnt;
      msda = 1'b1; scl = 1'b1; waitQ(Q);
      msda = 1'b0; waitQ(Q);
      msda = 1'b1; waitQ(Q);
      chk(illCnt == ill0 + 1, "R6 illegal pulse count", illCnt - ill0, 1);
      chk(!addressed, "R6 not addressed", int'(addressed), 0);
    end

    // R7 strap open fault
    strapOpen = 1'b1; waitQ(3);
    chk(strapFault, "R7 fault set", int'(strapFault), 1);
    strapOpen = 1'b0; waitQ(3);
    chk(!strapFault, "R7 fault clear", int'(strapFault), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule